// File: doc/BRIEF.md
# MDIO Management Engine with Status Polling

This block talks to an Ethernet PHY over the two-wire management bus. It produces the management clock by dividing the system clock and frames every access as a 64-bit serial word. It shifts data out on the falling clock edge and samples the PHY's reply on the rising edge. The bidirectional data pin is handled as three plain signals: an input, an output and an output enable.

When idle, the block polls two fixed PHY status registers, 0x0F and then 0x11, and keeps them in a 32-bit status word. A host register port lets software queue one register read or write. The request waits until the current poll pair has finished and then runs in the next free slot. A done flag reports completion, and reading the command word clears that flag. A separate command produces a PHY reset pulse of fixed length.

Top module: `mdio_poll_engine`

## Requirements
- R1: After reset, `mdc` and `mdio_oe` are low, `phy_reset` is low, and reading the command word (address 0) or the status word (address 3) returns zero.
- R2: `mdc` is periodic with a period of 2^DIV_BITS system clocks, high for half of it.
- R3: A host write produces one frame of 64 `mdc` periods, sent most significant bit first: 32 ones, start 01, opcode 01, the PHY address, the register, turnaround 10, then the 16 data bits held at address 1. `mdio_oe` is high for all 64 bits.
- R4: A read frame carries opcode 10. `mdio_oe` is high only for the first 46 bits, so the line is released from the turnaround onward. The 16 bits sampled in the last 16 periods go into the data-in register (address 2).
- R5: With no host request pending, the engine reads register 0x0F and then register 0x11, over and over. The status word (address 3) holds the 0x0F result in bits 31:16 and the 0x11 result in bits 15:0.
- R6: A command written at any time is held pending and is never dropped. It runs as the frame that directly follows the next completed 0x11 poll.
- R7: Command word layout on address 0: bits 4:0 are the register and bit 5 set means write. On read-back, bit 31 is the done flag, which goes high when the host frame ends. A read that sees the flag set clears it, so the next read shows bit 31 low.
- R8: A write to address 4 drives `phy_reset` high for exactly 255 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register select: 0 command, 1 data out, 2 data in, 3 status, 4 PHY reset |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe; read data is combinational |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 32 | Read data for the selected register |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Data pin input |
| mdio_out | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| phy_reset | output | 1 | PHY reset, asserted for 255 clocks |

## Verification
The assertions assume the host raises `host_wr` or `host_rd` for single cycles and never both at once. They also assume `mdio_in` changes only near the falling edge of `mdc`, so the rising-edge sample always sees a settled value. The bench's PHY model follows both rules: it changes its reply bit on the falling edge of `mdc`, and every host access is a one-cycle strobe launched on the falling edge of the system clock. New commands are issued only after the previous one has finished, except in the scenario that deliberately lands a request in the middle of a poll frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int unsigned PRE_BITS   = 32;
   localparam int unsigned FRAME_BITS = PRE_BITS + 32;
   // index (1-based bit count) of the last bit a read frame drives
   localparam int unsigned DRIVE_LAST = PRE_BITS + 14;

   localparam logic [2:0] HA_CMD  = 3'd0;
   localparam logic [2:0] HA_DOUT = 3'd1;
   localparam logic [2:0] HA_DIN  = 3'd2;
   localparam logic [2:0] HA_STAT = 3'd3;
   localparam logic [2:0] HA_RST  = 3'd4;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   function automatic logic [FRAME_BITS-1:0] mk_frame(input logic wr, input logic [4:0] phy,
                                                      input logic [4:0] ra, input logic [15:0] d);
      return {{PRE_BITS{1'b1}}, 2'b01, (wr ? OP_WR : OP_RD), phy, ra,
              (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
   endfunction
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
   parameter int unsigned DIV_BITS = 6
) (
   input  logic clk,
   input  logic rst,
   output logic mdc_o,
   output logic rise_en,
   output logic fall_en
);
   logic [DIV_BITS-1:0] div_cnt;
   logic mdc_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_cnt <= '0;
         mdc_o   <= 1'b0;
         mdc_d   <= 1'b0;
      end else begin
         div_cnt <= div_cnt + 1'b1;
         mdc_o   <= div_cnt[DIV_BITS-1];
         mdc_d   <= mdc_o;
      end
   end

   assign rise_en = mdc_o & ~mdc_d;
   assign fall_en = ~mdc_o & mdc_d;

   // edge enables are single-cycle and the clock is still high after a rise
   assert_rise_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      rise_en |=> (!rise_en && mdc_o));
   assert_fall_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      fall_en |=> (!fall_en && !mdc_o));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
   import mdio_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  rise_en,
   input  logic                  fall_en,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] frame,
   input  logic                  is_wr,
   output logic                  busy,
   output logic                  done,
   output logic [15:0]           rx_data,
   input  logic                  mdio_in,
   output logic                  mdio_out,
   output logic                  mdio_oe
);
   localparam int unsigned IDX_W = $clog2(FRAME_BITS + 1);

   typedef enum logic [1:0] {SH_IDLE, SH_ARM, SH_RUN} sh_state_e;
   sh_state_e st;
   logic [FRAME_BITS-1:0] sreg;
   logic [IDX_W-1:0] idx;
   logic [15:0] rx_sh;
   logic wr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st <= SH_IDLE; sreg <= '0; idx <= '0; rx_sh <= '0;
         wr_q <= 1'b0; done <= 1'b0; rx_data <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            SH_IDLE: if (start) begin
               sreg <= frame;
               wr_q <= is_wr;
               st   <= SH_ARM;
            end
            // first-increment step: moves the bit index off zero so a
            // transaction covers the full frame length in clock periods
            SH_ARM: if (fall_en) begin
               st  <= SH_RUN;
               idx <= IDX_W'(1);
            end
            SH_RUN: begin
               if (rise_en) rx_sh <= {rx_sh[14:0], mdio_in};
               if (fall_en) begin
                  if (idx == IDX_W'(FRAME_BITS)) begin
                     st      <= SH_IDLE;
                     done    <= 1'b1;
                     rx_data <= rx_sh;
                  end else begin
                     sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
                     idx  <= idx + 1'b1;
                  end
               end
            end
            default: st <= SH_IDLE;
         endcase
      end
   end

   assign busy     = (st != SH_IDLE);
   assign mdio_out = (st == SH_RUN) ? sreg[FRAME_BITS-1] : 1'b1;
   assign mdio_oe  = (st == SH_RUN) && (wr_q || (idx <= IDX_W'(DRIVE_LAST)));

   // a read frame lets go of the line exactly at the turnaround bit
   assert_release_ta_R4: assert property (@(posedge clk) disable iff (rst)
      ($fell(mdio_oe) && !wr_q && st == SH_RUN) |-> (idx == IDX_W'(DRIVE_LAST + 1)));
   // a start request is only ever accepted from idle
   assert_start_idle_R6: assert property (@(posedge clk) disable iff (rst)
      start |-> (st == SH_IDLE));
endmodule

// File: rtl/phy_reset_timer.sv
module phy_reset_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic active
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (load)        cnt <= '1;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);

   assert_pulse_end_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(active) |-> ($past(cnt) == CNT_W'(1) && !$past(load)));
endmodule

// File: rtl/mdio_poll_engine.sv
module mdio_poll_engine
   import mdio_pkg::*;
#(
   parameter int unsigned DIV_BITS       = 6,
   parameter logic [4:0]  PHY_ADDR       = 5'd1,
   parameter logic [4:0]  POLL_REG_A     = 5'h0F,
   parameter logic [4:0]  POLL_REG_B     = 5'h11,
   parameter int unsigned RST_CNT_W      = 8,
   parameter bit          RST_ACTIVE_LOW = 1'b0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [2:0]  host_addr,
   input  logic        host_wr,
   input  logic        host_rd,
   input  logic [15:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        mdc,
   input  logic        mdio_in,
   output logic        mdio_out,
   output logic        mdio_oe,
   output logic        phy_reset
);
   if (DIV_BITS < 2) begin : g_bad_div
      $error("DIV_BITS must be at least 2");
   end
   if (RST_CNT_W < 2) begin : g_bad_rst
      $error("RST_CNT_W must be at least 2");
   end
   if (POLL_REG_A == POLL_REG_B) begin : g_bad_poll
      $error("poll registers must differ");
   end

   typedef enum logic [2:0] {
      ST_ISSUE_A, ST_WAIT_A, ST_ISSUE_B, ST_WAIT_B, ST_CHECK, ST_WAIT_H
   } poll_state_e;

   logic rise_en, fall_en;
   logic sh_start, sh_busy, sh_done, sh_wr;
   logic [FRAME_BITS-1:0] sh_frame;
   logic [15:0] sh_rx;
   poll_state_e st;
   logic [5:0]  cmd_reg;
   logic        done_flag, pending, act_wr;
   logic [15:0] dout_reg, din_reg;
   logic [31:0] stat_reg;
   logic        rst_active;

   mdc_gen #(.DIV_BITS(DIV_BITS)) u_mdc (
      .clk(clk), .rst(rst), .mdc_o(mdc), .rise_en(rise_en), .fall_en(fall_en));

   mdio_shifter u_shift (
      .clk(clk), .rst(rst), .rise_en(rise_en), .fall_en(fall_en),
      .start(sh_start), .frame(sh_frame), .is_wr(sh_wr), .busy(sh_busy),
      .done(sh_done), .rx_data(sh_rx), .mdio_in(mdio_in),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe));

   phy_reset_timer #(.CNT_W(RST_CNT_W)) u_rst (
      .clk(clk), .rst(rst), .load(host_wr && host_addr == HA_RST), .active(rst_active));

   if (RST_ACTIVE_LOW) begin : g_rst_low
      assign phy_reset = ~rst_active;
   end else begin : g_rst_high
      assign phy_reset = rst_active;
   end

   logic cmd_wr, rd_clear, host_start, host_fin;
   assign cmd_wr     = host_wr && host_addr == HA_CMD;
   assign rd_clear   = host_rd && host_addr == HA_CMD && done_flag;
   assign host_start = (st == ST_CHECK) && pending && !sh_busy;
   assign host_fin   = (st == ST_WAIT_H) && sh_done;

   always_comb begin
      sh_start = 1'b0;
      sh_wr    = 1'b0;
      sh_frame = mk_frame(1'b0, PHY_ADDR, POLL_REG_A, 16'h0000);
      unique case (st)
         ST_ISSUE_A: sh_start = !sh_busy;
         ST_ISSUE_B: begin
            sh_start = !sh_busy;
            sh_frame = mk_frame(1'b0, PHY_ADDR, POLL_REG_B, 16'h0000);
         end
         ST_CHECK: begin
            sh_start = host_start;
            sh_wr    = cmd_reg[5];
            sh_frame = mk_frame(cmd_reg[5], PHY_ADDR, cmd_reg[4:0], dout_reg);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st <= ST_ISSUE_A; stat_reg <= '0; din_reg <= '0; act_wr <= 1'b0;
      end else begin
         unique case (st)
            ST_ISSUE_A: if (sh_start) st <= ST_WAIT_A;
            ST_WAIT_A: if (sh_done) begin
               stat_reg[31:16] <= sh_rx;
               st <= ST_ISSUE_B;
            end
            ST_ISSUE_B: if (sh_start) st <= ST_WAIT_B;
            ST_WAIT_B: if (sh_done) begin
               stat_reg[15:0] <= sh_rx;
               st <= ST_CHECK;
            end
            ST_CHECK: begin
               if (host_start) begin
                  act_wr <= cmd_reg[5];
                  st     <= ST_WAIT_H;
               end else if (!pending) begin
                  st <= ST_ISSUE_A;
               end
            end
            ST_WAIT_H: if (sh_done) begin
               if (!act_wr) din_reg <= sh_rx;
               st <= ST_ISSUE_A;
            end
            default: st <= ST_ISSUE_A;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_reg <= '0; dout_reg <= '0; pending <= 1'b0; done_flag <= 1'b0;
      end else begin
         if (cmd_wr) cmd_reg <= host_wdata[5:0];
         if (host_wr && host_addr == HA_DOUT) dout_reg <= host_wdata;
         pending <= cmd_wr || (pending && !host_start);
         if (host_fin)                 done_flag <= 1'b1;
         else if (cmd_wr || rd_clear)  done_flag <= 1'b0;
      end
   end

   always_comb begin
      unique case (host_addr)
         HA_CMD:  host_rdata = {done_flag, 25'd0, cmd_reg};
         HA_DOUT: host_rdata = {16'd0, dout_reg};
         HA_DIN:  host_rdata = {16'd0, din_reg};
         HA_STAT: host_rdata = stat_reg;
         default: host_rdata = 32'd0;
      endcase
   end

   // a queued request survives until it is launched as a frame
   assert_pending_kept_R6: assert property (@(posedge clk) disable iff (rst)
      (pending && !host_start) |=> pending);
   // the done flag only rises at the end of a host frame
   assert_done_source_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(done_flag) |-> $past(host_fin));
   // the status word changes only right after a completed frame
   assert_status_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(sh_done) |-> $stable(stat_reg));
endmodule

// File: tb/sim_mdio_poll_engine.sv
module sim_mdio_poll_engine;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0] host_addr = 3'd0;
   logic host_wr = 1'b0, host_rd = 1'b0;
   logic [15:0] host_wdata = 16'd0;
   logic [31:0] host_rdata;
   logic mdc, mdio_out, mdio_oe, phy_reset;
   logic mdio_in = 1'b1;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   mdio_poll_engine #(.DIV_BITS(4)) u0 (
      .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc), .mdio_in(mdio_in),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .phy_reset(phy_reset));

   // ---------------- PHY model ----------------
   logic [15:0] phy_regs [0:31];
   logic [63:0] fr = '0;
   logic [63:0] log_fr [0:63];
   int          log_oe [0:63];
   int n_frames = 0, pos = 0, oe_cnt = 0;
   logic in_frame = 1'b0, m_bit;
   logic [1:0] cur_op = 2'b00;
   logic [15:0] rd_val = '0;

   function automatic logic [15:0] phy_init(input int r);
      return 16'hC000 ^ 16'(r * 16'h0421);
   endfunction

   initial for (int i = 0; i < 32; i++) phy_regs[i] = phy_init(i);

   always @(posedge mdc) begin
      m_bit = mdio_oe ? mdio_out : mdio_in;
      if (!in_frame && mdio_oe) begin
         in_frame = 1'b1; pos = 0; fr = '0; oe_cnt = 0;
      end
      if (in_frame) begin
         fr = {fr[62:0], m_bit};
         if (mdio_oe) oe_cnt++;
         pos++;
         if (pos == 46) begin
            cur_op = fr[11:10];
            rd_val = phy_regs[fr[4:0]];
         end
         if (pos == 64) begin
            in_frame = 1'b0;
            if (n_frames < 64) begin
               log_fr[n_frames] = fr;
               log_oe[n_frames] = oe_cnt;
            end
            n_frames++;
            if (fr[29:28] == 2'b01) phy_regs[fr[22:18]] = fr[15:0];
         end
      end
   end

   always @(negedge mdc) begin
      if (in_frame && cur_op == 2'b10 && pos >= 46)
         mdio_in = (pos == 46) ? 1'b1 : (pos == 47) ? 1'b0 : rd_val[63 - pos];
      else
         mdio_in = 1'b1;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wait_done(output logic [31:0] v);
      v = '0;
      for (int i = 0; i < 20000; i++) begin
         hread(3'd0, v);
         if (v[31]) break;
      end
   endtask

   task automatic wait_frames(input int n);
      int target;
      target = n_frames + n;
      while (n_frames < target) @(negedge clk);
   endtask

   function automatic int find_reg(input int from, input logic [4:0] r, input logic [1:0] op);
      for (int i = from; i < n_frames && i < 64; i++)
         if (log_fr[i][22:18] == r && log_fr[i][29:28] == op) return i;
      return -1;
   endfunction

   // ---------------- scenarios ----------------
   task automatic t_reset;
      logic [31:0] v;
      @(negedge clk);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe in reset", {mdc, mdio_oe}, 0);
      chk(phy_reset == 1'b0, "R1 phy_reset in reset", phy_reset, 0);
      rst = 1'b0;
      hread(3'd0, v);
      chk(v == 0, "R1 command word after reset", v, 0);
      hread(3'd3, v);
      chk(v == 0, "R1 status word after reset", v, 0);
   endtask

   task automatic t_mdc_period;
      int hi, per;
      while (mdc !== 1'b0) @(negedge clk);
      while (mdc !== 1'b1) @(negedge clk);
      hi = 0; per = 0;
      while (mdc === 1'b1) begin hi++; per++; @(negedge clk); end
      while (mdc === 1'b0) begin per++; @(negedge clk); end
      chk(per == 16, "R2 mdc period", per, 16);
      chk(hi == 8, "R2 mdc high time", hi, 8);
   endtask

   task automatic t_poll;
      logic [31:0] v;
      wait_frames(3 - (n_frames > 3 ? 3 : n_frames));
      chk(log_fr[0][63:16] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd1, 5'h0F, 2'b10},
          "R5 first poll frame reads 0x0F", log_fr[0][63:16], 0);
      chk(log_fr[1][22:18] == 5'h11 && log_fr[1][29:28] == 2'b10,
          "R5 second poll frame reads 0x11", log_fr[1][22:18], 5'h11);
      chk(log_oe[0] == 46, "R4 read frame drives 46 bits", log_oe[0], 46);
      hread(3'd3, v);
      chk(v == {phy_init(15), phy_init(17)}, "R5 status word", v, {phy_init(15), phy_init(17)});
   endtask

   task automatic t_host_write;
      logic [31:0] v;
      int idx, base;
      base = n_frames;
      hwrite(3'd1, 16'hBEEF);
      hwrite(3'd0, 16'h0023);
      wait_done(v);
      chk(v[31] == 1'b1 && v[5:0] == 6'h23, "R7 done flag and fields", v, 32'h8000_0023);
      hread(3'd0, v);
      chk(v[31] == 1'b0, "R7 done cleared by read", v, 32'h0000_0023);
      idx = find_reg(base, 5'd3, 2'b01);
      chk(idx > 0, "R3 write frame present", idx, 1);
      if (idx > 0) begin
         chk(log_fr[idx] == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, 5'd3, 2'b10, 16'hBEEF},
             "R3 write frame bits", log_fr[idx], {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, 5'd3, 2'b10, 16'hBEEF});
         chk(log_oe[idx] == 64, "R3 write drives all bits", log_oe[idx], 64);
         chk(log_fr[idx-1][22:18] == 5'h11, "R6 host frame follows 0x11 poll", log_fr[idx-1][22:18], 5'h11);
      end
      chk(phy_regs[3] == 16'hBEEF, "R3 PHY register written", phy_regs[3], 16'hBEEF);
   endtask

   task automatic t_pending_read;
      logic [31:0] v;
      int idx, base, cnt;
      phy_regs[9] = 16'h1234;
      base = n_frames;
      // land the request in the middle of a poll frame
      while (!(in_frame && pos == 20)) @(negedge clk);
      hwrite(3'd0, 16'h0009);
      wait_done(v);
      chk(v[31] == 1'b1 && v[5] == 1'b0, "R7 read command done", v, 32'h8000_0009);
      cnt = 0;
      for (int i = base; i < n_frames && i < 64; i++)
         if (log_fr[i][22:18] == 5'd9) cnt++;
      chk(cnt == 1, "R6 pending request runs exactly once", cnt, 1);
      idx = find_reg(base, 5'd9, 2'b10);
      if (idx > 0)
         chk(log_fr[idx-1][22:18] == 5'h11, "R6 pending runs after 0x11", log_fr[idx-1][22:18], 5'h11);
      else
         chk(1'b0, "R6 pending frame missing", idx, 1);
      hread(3'd2, v);
      chk(v == 32'h1234, "R4 data-in register", v, 32'h1234);
   endtask

   task automatic t_status_update;
      logic [31:0] v;
      phy_regs[17] = 16'h5A5A;
      phy_regs[15] = 16'h0F0F;
      wait_frames(4);
      hread(3'd3, v);
      chk(v == 32'h0F0F_5A5A, "R5 status follows PHY", v, 32'h0F0F_5A5A);
   endtask

   task automatic t_phy_reset;
      int hi;
      hwrite(3'd4, 16'h0001);
      hi = 0;
      while (phy_reset === 1'b1 && hi < 1000) begin hi++; @(negedge clk); end
      chk(hi == 255, "R8 reset pulse length", hi, 255);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset;
      t_mdc_period;
      t_poll;
      t_host_write;
      t_pending_read;
      t_status_update;
      t_phy_reset;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule